// File: doc/BRIEF.md
# Exponent-Mantissa Baud Rate Generator

This block produces the timing strobes for an asynchronous serial channel. A 10-bit divisor sets the rate. Its low six bits are a mantissa N and its top four bits are an exponent M. The 16x oversampling strobe fires once every (N+1)·2^M input clock cycles, so the bit rate equals (clock / 16) / ((N+1)·2^M). With the nominal 29.4912 MHz clock the base rate is 1,843,200, and the default divisor (N=47, M=2) gives 9600 baud.

The host loads the divisor in two writes, because it does not fit in one byte. Divisor bits 7:0 go into a dedicated byte register. Divisor bits 9:8 sit in bits 7:6 of a shared control register. The host updates that control register by reading it, changing bits 7:6 and writing it back, so the block keeps all eight control bits and returns both registers on read ports.

The written divisor is staged and only moves into the active counters at the end of the current strobe period, so no runt strobe can occur. A status output warns when the staged exponent is zero, because that setting is unreliable with input clocks above 10 MHz. A bit-rate strobe marks every sixteenth oversampling strobe.

Top module: `bg_baud_gen`

## Requirements
- R1: While the active divisor is N (bits 5:0) and M (bits 9:6), `tick16_o` is high for exactly one cycle out of every (N+1)·2^M clock cycles.
- R2: `div_act_o` shows the active divisor with N in bits 5:0 and M in bits 9:6, and this packing sets the strobe period.
- R3: A write with `wr_sel_i`=0 loads `wr_data_i` into the low byte register (divisor bits 7:0). A write with `wr_sel_i`=1 loads all eight bits into the control register, whose bits 7:6 are divisor bits 9:8. Both registers read back on their own ports in the cycle after the write.
- R4: A low-byte write leaves the control register unchanged, and the divisor logic never alters control bits 5:0.
- R5: The staged divisor {control[7:6], low byte} becomes active only in the cycle where a `tick16_o` strobe is issued. The period in progress completes with the old divisor, and when several writes land in one period only the last staged value is used.
- R6: `bit_tick_o` is high together with every sixteenth `tick16_o` strobe, counting from reset or clear, and at no other time.
- R7: `exp_zero_o` is high exactly when the staged exponent {control[7:6], low[7:6]} is zero.
- R8: An asynchronous reset (`rst_ni` low), or a synchronous clear (`clr_i` high at a clock edge), zeroes both counters and both strobes. It also loads the default divisor 0x0AF (N=47, M=2, period 192) into both the active and the staged copies, sets the control register to 0x00 and the low byte to 0xAF. The first strobe follows 192 cycles later.
- R9: With N=0 and M=0 active, `tick16_o` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_i | input | 1 | Synchronous clear to the default state |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 low divisor byte, 1 control register |
| wr_data_i | input | 8 | Write data |
| lo_q_o | output | 8 | Low divisor byte register contents |
| ctl_q_o | output | 8 | Control register contents (bits 7:6 are divisor bits 9:8) |
| div_act_o | output | 10 (DIV_W) | Active divisor {M, N} |
| exp_zero_o | output | 1 | Staged exponent is zero |
| tick16_o | output | 1 | One-cycle oversampling strobe |
| bit_tick_o | output | 1 | One-cycle bit-rate strobe |

## Verification
The bench builds the block with its default parameters: a 6-bit mantissa, a 4-bit exponent and the 9600-baud default divisor. At these values the reset period of 192 cycles reaches a bit-rate strobe within about three thousand cycles. The full-speed setting N=0, M=0 and a divisor with the top exponent of 15 (a 32768-cycle period) both fit in the run, so the prescaler mask is tried at its narrowest and widest settings. Because the mantissa is six bits wide, writes that land in the middle of a period and back-to-back divisor changes can be checked against the model without long waits.

// File: rtl/bg_pkg.sv
package bg_pkg;
  typedef enum logic {
    SEL_LO  = 1'b0,
    SEL_CTL = 1'b1
  } reg_sel_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/bg_div_regs.sv
module bg_div_regs
  import bg_pkg::*;
#(
  parameter int unsigned      DIV_W   = 10,
  parameter logic [DIV_W-1:0] DEF_DIV = 10'h0AF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] lo_q_o,
  output logic [BYTE_W-1:0] ctl_q_o,
  output logic [DIV_W-1:0]  staged_o
);
  localparam int unsigned HI_W = DIV_W - BYTE_W;
  localparam logic [BYTE_W-1:0] LO_RST  = DEF_DIV[BYTE_W-1:0];
  localparam logic [BYTE_W-1:0] CTL_RST = {DEF_DIV[DIV_W-1:BYTE_W], {(BYTE_W-HI_W){1'b0}}};

  logic [BYTE_W-1:0] lo_q, lo_d, ctl_q, ctl_d;
  logic              lo_en, ctl_en;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(wr_sel_i);

  always_comb begin
    lo_en  = clr_i | (wr_en_i & (sel == SEL_LO));
    ctl_en = clr_i | (wr_en_i & (sel == SEL_CTL));
    lo_d   = clr_i ? LO_RST  : wr_data_i;
    ctl_d  = clr_i ? CTL_RST : wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= LO_RST;
      ctl_q <= CTL_RST;
    end else begin
      if (lo_en)  lo_q  <= lo_d;
      if (ctl_en) ctl_q <= ctl_d;
    end
  end

  assign lo_q_o   = lo_q;
  assign ctl_q_o  = ctl_q;
  assign staged_o = {ctl_q[BYTE_W-1 -: HI_W], lo_q};
endmodule

// File: rtl/bg_prescale.sv
module bg_prescale #(
  parameter int unsigned EXP_W = 4,
  parameter int unsigned PRE_W = (1 << EXP_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             restart_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             pre_en_o
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d, mask;

  for (genvar gi = 0; gi < PRE_W; gi++) begin : g_mask
    assign mask[gi] = (exp_i > EXP_W'(gi));
  end

  assign pre_en_o = &(pcnt_q | ~mask);

  always_comb begin
    if (clr_i || restart_i) pcnt_d = '0;
    else                    pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else         pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/bg_mant.sv
module bg_mant #(
  parameter int unsigned      MANT_W  = 6,
  parameter int unsigned      EXP_W   = 4,
  parameter int unsigned      DIV_W   = MANT_W + EXP_W,
  parameter logic [DIV_W-1:0] DEF_DIV = 10'h0AF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             pre_en_i,
  input  logic [DIV_W-1:0] staged_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] act_o,
  output logic [EXP_W-1:0] exp_o
);
  logic [MANT_W-1:0] mcnt_q, mcnt_d;
  logic [DIV_W-1:0]  act_q, act_d;
  logic              term;

  assign term   = (mcnt_q == '0);
  assign tick_o = pre_en_i & term & ~clr_i;

  always_comb begin
    mcnt_d = mcnt_q;
    act_d  = act_q;
    if (clr_i) begin
      mcnt_d = DEF_DIV[MANT_W-1:0];
      act_d  = DEF_DIV;
    end else if (tick_o) begin
      mcnt_d = staged_i[MANT_W-1:0];
      act_d  = staged_i;
    end else if (pre_en_i) begin
      mcnt_d = mcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcnt_q <= DEF_DIV[MANT_W-1:0];
      act_q  <= DEF_DIV;
    end else begin
      mcnt_q <= mcnt_d;
      act_q  <= act_d;
    end
  end

  assign act_o = act_q;
  assign exp_o = act_q[DIV_W-1:MANT_W];
endmodule

// File: rtl/bg_bitdiv.sv
module bg_bitdiv #(
  parameter int unsigned OVS = 16,
  parameter int unsigned CW  = $clog2(OVS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic tick_o,
  output logic bit_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d, bit_q, bit_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(OVS - 1));

  always_comb begin
    tick_d = tick_i & ~clr_i;
    bit_d  = tick_i & ~clr_i & wrap;
    if (clr_i)       cnt_d = '0;
    else if (tick_i) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
      bit_q  <= bit_d;
    end
  end

  assign tick_o = tick_q;
  assign bit_o  = bit_q;
endmodule

// File: rtl/bg_baud_gen.sv
module bg_baud_gen
  import bg_pkg::*;
#(
  parameter int unsigned      MANT_W  = 6,
  parameter int unsigned      EXP_W   = 4,
  parameter int unsigned      OVS     = 16,
  parameter int unsigned      DIV_W   = MANT_W + EXP_W,
  parameter logic [DIV_W-1:0] DEF_DIV = 10'h0AF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       lo_q_o,
  output logic [7:0]       ctl_q_o,
  output logic [DIV_W-1:0] div_act_o,
  output logic             exp_zero_o,
  output logic             tick16_o,
  output logic             bit_tick_o
);
  localparam int unsigned PRE_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0] staged;
  logic [EXP_W-1:0] act_exp;
  logic             pre_en, tick_c;

  bg_div_regs #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_regs (
    .clk_i, .rst_ni, .clr_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .lo_q_o, .ctl_q_o, .staged_o(staged)
  );

  bg_prescale #(.EXP_W(EXP_W), .PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .clr_i, .restart_i(tick_c), .exp_i(act_exp), .pre_en_o(pre_en)
  );

  bg_mant #(.MANT_W(MANT_W), .EXP_W(EXP_W), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_mant (
    .clk_i, .rst_ni, .clr_i, .pre_en_i(pre_en), .staged_i(staged),
    .tick_o(tick_c), .act_o(div_act_o), .exp_o(act_exp)
  );

  bg_bitdiv #(.OVS(OVS)) u_bit (
    .clk_i, .rst_ni, .clr_i, .tick_i(tick_c), .tick_o(tick16_o), .bit_o(bit_tick_o)
  );

  assign exp_zero_o = (staged[DIV_W-1:MANT_W] == '0);
endmodule

// File: rtl/bg_baud_gen_chk.sv
module bg_baud_gen_chk #(
  parameter int unsigned      DIV_W   = 10,
  parameter int unsigned      OVS     = 16,
  parameter logic [DIV_W-1:0] DEF_DIV = 10'h0AF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [7:0]       wr_data_i,
  input logic [7:0]       ctl_q_o,
  input logic [DIV_W-1:0] div_act_o,
  input logic             exp_zero_o,
  input logic             tick16_o,
  input logic             bit_tick_o
);
  localparam int unsigned HI_W = DIV_W - 8;
  localparam int unsigned CW   = $clog2(OVS);

  logic [CW-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= '0;
    else if (clr_i)     seen_q <= '0;
    else if (tick16_o)  seen_q <= bit_tick_o ? '0 : seen_q + 1'b1;
  end

  assert_bit_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> tick16_o);

  assert_bit_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> (seen_q == CW'(OVS - 1)));

  assert_act_only_at_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(div_act_o) && !$past(clr_i)) |-> tick16_o);

  assert_ctl_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && !clr_i) |=> (ctl_q_o == $past(wr_data_i)));

  assert_lo_keeps_ctl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && !clr_i) |=> $stable(ctl_q_o));

  assert_clear_state_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!tick16_o && !bit_tick_o && div_act_o == DEF_DIV));

  assert_exp_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && !clr_i && (wr_data_i[7 -: HI_W] != '0)) |=> !exp_zero_o);
endmodule

bind bg_baud_gen bg_baud_gen_chk #(.DIV_W(DIV_W), .OVS(OVS), .DEF_DIV(DEF_DIV)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .ctl_q_o(ctl_q_o), .div_act_o(div_act_o),
  .exp_zero_o(exp_zero_o), .tick16_o(tick16_o), .bit_tick_o(bit_tick_o)
);

// File: tb/bg_baud_gen_bench.sv
`timescale 1ns/1ps
module bg_baud_gen_bench;
  localparam int DEF = 'h0AF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] lo_q, ctl_q;
  logic [9:0] div_act;
  logic       exp_zero, tick16, bit_tick;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  int m_ph, m_per, m_c16, m_lo, m_ctl, m_act;
  bit m_tick, m_bit;

  always #2.5 clk = ~clk;

  bg_baud_gen u_bg_baud_gen (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .lo_q_o(lo_q), .ctl_q_o(ctl_q), .div_act_o(div_act),
    .exp_zero_o(exp_zero), .tick16_o(tick16), .bit_tick_o(bit_tick)
  );

  function automatic int period_of(int d);
    return ((d % 64) + 1) * (1 << (d / 64));
  endfunction

  task automatic model_default();
    m_ph = 0; m_act = DEF; m_per = period_of(DEF); m_c16 = 0;
    m_lo = DEF % 256; m_ctl = (DEF / 256) * 64; m_tick = 0; m_bit = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      model_default();
    end else begin
      m_tick = (m_ph == m_per - 1);
      m_bit  = m_tick && (m_c16 == 15);
      if (m_tick) begin
        m_ph  = 0;
        m_c16 = (m_c16 + 1) % 16;
        m_act = (m_ctl / 64) * 256 + m_lo;
        m_per = period_of(m_act);
      end else begin
        m_ph++;
      end
      if (wr_en) begin
        if (wr_sel) m_ctl = int'(wr_data);
        else        m_lo  = int'(wr_data);
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (started && rst_n) begin
      check("R1", "tick16", int'(tick16), int'(m_tick));
      check("R6", "bit_tick", int'(bit_tick), int'(m_bit));
      check("R2", "div_act", int'(div_act), m_act);
      check("R3", "lo_q", int'(lo_q), m_lo);
      check("R4", "ctl_q", int'(ctl_q), m_ctl);
      check("R7", "exp_zero", int'(exp_zero), int'(((m_ctl / 64) * 4 + m_lo / 64) == 0));
    end
    if (cycles > 190000 && !done) begin
      miscompares++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    started = 1'b1;
    // R8: reset state, visible before any edge after release
    check("R8", "reset tick16", int'(tick16), 0);
    check("R8", "reset div_act", int'(div_act), DEF);
    check("R8", "reset ctl_q", int'(ctl_q), 0);
    @(negedge clk);
    idle(3200);                           // default period 192, includes a bit tick (R6)

    // host read-modify-write of the control register, then N=0 M=0 (R9, R7)
    wr(1'b1, 8'h15);
    wr(1'b0, 8'h00);
    wr(1'b1, {2'b00, ctl_q[5:0]});
    check("R5", "divisor held until period end", int'(div_act), DEF);
    for (int i = 0; i < 400 && div_act != 10'h000; i++) @(negedge clk);
    @(negedge clk);
    begin
      int n = 0;
      for (int i = 0; i < 20; i++) begin
        if (tick16) n++;
        @(negedge clk);
      end
      check("R9", "strobes in 20 cycles", n, 20);
    end

    // N=2, M=5 (period 96)
    wr(1'b0, 8'h42);
    wr(1'b1, {2'b01, ctl_q[5:0]});
    idle(2000);

    // low byte only: control must stay (R4); N=1, M=6
    wr(1'b0, 8'h81);
    idle(1000);

    // several writes in one period, only the last is taken (R5)
    wr(1'b1, {2'b00, ctl_q[5:0]});
    wr(1'b0, 8'h05);
    wr(1'b0, 8'h07);
    idle(300);

    // synchronous clear mid-run (R8)
    idle(5);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R8", "clear div_act", int'(div_act), DEF);
    check("R8", "clear ctl_q", int'(ctl_q), 0);
    check("R8", "clear lo_q", int'(lo_q), DEF);
    idle(400);

    // widest exponent: N=0, M=15 (period 32768)
    wr(1'b0, 8'hC0);
    wr(1'b1, 8'hC0);
    idle(70000);

    finish_run();
  end
endmodule